// File: doc/BRIEF.md
# Multiplexed-Address Bit-Wide Dynamic Memory

This block is a synthesizable, cycle-level model of a 64K x 1 dynamic memory: 256 rows of 256 single-bit cells, reached through an 8-bit address bus that carries the row half and the column half at different times. A row strobe captures the row half and copies that whole row into a row buffer. Column strobes then read or write single bits of the buffer. A read/write-not level selects the direction, and data enters and leaves on separate 1-bit pins. A close command writes the buffer back to the array and frees the row. A refresh command rewrites one row per operation, taken from an internal counter that steps through all rows and wraps. Refresh is only taken while no row is open.

A small front-end sequencer turns a flat 16-bit request into the three strobe phases: open the row, access the column, close the row. Each phase takes one clock. While the sequencer is busy it owns the strobe bus. While it is idle, the raw strobe pins drive the array directly, so the model can be run either way.

Top module: `mux_addr_dram`

## Requirements
- R1: After reset no row is open, data_out is 0, refresh_row is 0, busy is 0 and rd_ready is 0.
- R2: A row strobe with no row open latches addr_bus as the row and opens it, so row_open is 1 after that edge. A row strobe while a row is open is ignored, and the open row stays in the buffer.
- R3: A column strobe with rd_nwr=1 and a row open puts the buffer bit at column addr_bus on data_out. The value appears after the strobe edge.
- R4: A column strobe with rd_nwr=0 and a row open stores data_in into the buffer bit at column addr_bus, leaves data_out unchanged, and is seen by later reads of that open row.
- R5: A close with a row open writes the buffer back to the array and clears row_open. Reopening that row later returns the data written before the close.
- R6: A column strobe while no row is open is ignored: data_out holds its value and no stored bit changes.
- R7: A refresh with no row open advances refresh_row by one, wrapping from 255 to 0, and leaves stored data intact. A refresh while a row is open leaves refresh_row unchanged.
- R8: A flat request (req_valid) taken while idle with no row open splits req_addr into row (bits 15:8) and column (bits 7:0). busy is then 1 for exactly three cycles. For a read (req_rd=1), rd_ready is 1 only in the third cycle, with the bit on data_out. A request made while a row is open is not taken.
- R9: While busy is 1, the raw strobe pins and new requests have no effect.
- R10: When several commands arrive in the same cycle, close wins over refresh, refresh wins over the row strobe, and the row strobe wins over the column strobe. The losing commands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Flat request strobe |
| req_rd | input | 1 | Flat request: 1 read, 0 write |
| req_addr | input | 16 | Flat address, row in 15:8, column in 7:0 |
| req_wdata | input | 1 | Flat write data |
| busy | output | 1 | Sequencer owns the strobe bus |
| rd_ready | output | 1 | Flat read bit valid on data_out |
| row_stb | input | 1 | Raw row strobe (open row) |
| col_stb | input | 1 | Raw column strobe (bit access) |
| close_row | input | 1 | Raw close: write back and free the row |
| refresh_req | input | 1 | Raw refresh of the next counter row |
| rd_nwr | input | 1 | Raw direction: 1 read, 0 write |
| addr_bus | input | 8 | Raw multiplexed address half |
| data_in | input | 1 | Raw write bit |
| data_out | output | 1 | Read bit |
| row_open | output | 1 | A row is held in the buffer |
| refresh_row | output | 8 | Next row the refresh counter will rewrite |

## Verification
The hardest case to reach is proving that the close really writes the buffer back to the array, because reads of an open row come from the buffer and never touch the array. The stimulus writes a bit, closes the row, touches a different row and refreshes, then reopens the first row and reads the bit back. Wrap of the refresh counter is reached by issuing the full 256 refreshes, with refreshes attempted while a row is open mixed in. The ignore rules for the raw pins during busy are exercised by driving those pins on the very cycles the sequencer holds the bus.

// File: rtl/mxd_pkg.sv
// Shared types for the multiplexed-address dynamic memory model.
package mxd_pkg;
    // Front-end sequencer phases: idle, open row, column access, close row.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_OPEN = 2'd1,
        SQ_COL  = 2'd2,
        SQ_SHUT = 2'd3
    } seq_state_t;
endpackage

// File: rtl/mxd_refresh_ctr.sv
// Row counter for refresh. It steps once per accepted refresh and wraps
// modulo 2**AW. It assumes step is only raised when a refresh is taken.
module mxd_refresh_ctr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] count
);
    // Advance the pointer on each accepted refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/mxd_array.sv
// Bit array with a one-row buffer. Commands are sampled on the clock edge.
// Priority: close, then refresh, then row strobe, then column strobe.
// The cells have no reset. The buffer and the output bit are reset.
module mxd_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_stb,
    input  logic          col_stb,
    input  logic          close_row,
    input  logic          refresh_req,
    input  logic          rd_nwr,
    input  logic [AW-1:0] addr_bus,
    input  logic          data_in,
    output logic          data_out,
    output logic          row_open,
    output logic [AW-1:0] refresh_row
);
    localparam int ROWS = 1 << AW;
    localparam int COLS = 1 << AW;

    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] row_buf;
    logic [AW-1:0]   row_q;

    logic            do_close, do_ref, do_open, do_col;
    logic            wr_en;
    logic [AW-1:0]   wr_idx;
    logic [COLS-1:0] wr_row;

    // Decode the single command that wins this cycle.
    always_comb begin
        do_close = close_row && row_open;
        do_ref   = !close_row && refresh_req && !row_open;
        do_open  = !close_row && !refresh_req && row_stb && !row_open;
        do_col   = !close_row && !refresh_req && !row_stb && col_stb && row_open;
    end

    // Select the array write: buffer write-back or row rewrite.
    always_comb begin
        wr_en  = do_close || do_ref;
        wr_idx = do_close ? row_q : refresh_row;
        wr_row = do_close ? row_buf : cells[refresh_row];
    end

    mxd_refresh_ctr #(.AW(AW)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (do_ref),
        .count (refresh_row)
    );

    // Cell storage, written one full row at a time.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_row;
    end

    // Row buffer, open flag, row latch and read bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            row_q    <= '0;
            row_buf  <= '0;
            data_out <= 1'b0;
        end else if (do_close) begin
            row_open <= 1'b0;
        end else if (do_open) begin
            row_open <= 1'b1;
            row_q    <= addr_bus;
            row_buf  <= cells[addr_bus];
        end else if (do_col) begin
            if (rd_nwr) data_out <= row_buf[addr_bus];
            else        row_buf[addr_bus] <= data_in;
        end
    end

    // R6
    col_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !row_open) |=> $stable(data_out));
    // R7
    ref_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && row_open) |=> $stable(refresh_row));
    // R2
    open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_stb && !row_open && !close_row && !refresh_req) |=> row_open);
    // R5
    close_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close_row && row_open) |=> !row_open);
endmodule

// File: rtl/mxd_seq.sv
// Front-end sequencer. It takes a flat request only when idle and no row
// is open, then spends one clock each on the row open, the column access
// and the close. rd_ready marks the read bit valid during the close cycle.
module mxd_seq
    import mxd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_rd,
    input  logic [2*AW-1:0] req_addr,
    input  logic            req_wdata,
    input  logic            row_open,
    output logic            busy,
    output logic            rd_ready,
    output logic            s_row_stb,
    output logic            s_col_stb,
    output logic            s_close,
    output logic            s_rd_nwr,
    output logic [AW-1:0]   s_addr,
    output logic            s_wdata
);
    seq_state_t      st;
    logic [2*AW-1:0] addr_q;
    logic            rd_q, wd_q;

    // Phase register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            addr_q <= '0;
            rd_q   <= 1'b0;
            wd_q   <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (req_valid && !row_open) begin
                    st     <= SQ_OPEN;
                    addr_q <= req_addr;
                    rd_q   <= req_rd;
                    wd_q   <= req_wdata;
                end
                SQ_OPEN: st <= SQ_COL;
                SQ_COL:  st <= SQ_SHUT;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Strobe and address outputs for the current phase.
    always_comb begin
        busy      = (st != SQ_IDLE);
        s_row_stb = (st == SQ_OPEN);
        s_col_stb = (st == SQ_COL);
        s_close   = (st == SQ_SHUT);
        rd_ready  = (st == SQ_SHUT) && rd_q;
        s_rd_nwr  = rd_q;
        s_wdata   = wd_q;
        s_addr    = (st == SQ_OPEN) ? addr_q[2*AW-1:AW] : addr_q[AW-1:0];
    end

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(busy, 2)) |=> !busy);
endmodule

// File: rtl/mux_addr_dram.sv
// Top level: the bit array behind a two-way strobe mux. The sequencer owns
// the strobe bus while busy. Otherwise the raw pins drive it.
module mux_addr_dram #(
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_rd,
    input  logic [2*AW-1:0] req_addr,
    input  logic            req_wdata,
    output logic            busy,
    output logic            rd_ready,
    input  logic            row_stb,
    input  logic            col_stb,
    input  logic            close_row,
    input  logic            refresh_req,
    input  logic            rd_nwr,
    input  logic [AW-1:0]   addr_bus,
    input  logic            data_in,
    output logic            data_out,
    output logic            row_open,
    output logic [AW-1:0]   refresh_row
);
    logic          s_row, s_col, s_close, s_rd, s_wd;
    logic [AW-1:0] s_addr;
    logic          a_row, a_col, a_close, a_ref, a_rd, a_wd;
    logic [AW-1:0] a_addr;

    mxd_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .row_open  (row_open),
        .busy      (busy),
        .rd_ready  (rd_ready),
        .s_row_stb (s_row),
        .s_col_stb (s_col),
        .s_close   (s_close),
        .s_rd_nwr  (s_rd),
        .s_addr    (s_addr),
        .s_wdata   (s_wd)
    );

    // Hand the strobe bus to whichever side owns it.
    always_comb begin
        a_row   = busy ? s_row   : row_stb;
        a_col   = busy ? s_col   : col_stb;
        a_close = busy ? s_close : close_row;
        a_ref   = busy ? 1'b0    : refresh_req;
        a_rd    = busy ? s_rd    : rd_nwr;
        a_addr  = busy ? s_addr  : addr_bus;
        a_wd    = busy ? s_wd    : data_in;
    end

    mxd_array #(.AW(AW)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_stb     (a_row),
        .col_stb     (a_col),
        .close_row   (a_close),
        .refresh_req (a_ref),
        .rd_nwr      (a_rd),
        .addr_bus    (a_addr),
        .data_in     (a_wd),
        .data_out    (data_out),
        .row_open    (row_open),
        .refresh_row (refresh_row)
    );

    // R8
    ready_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(a_col && a_rd && busy));
    // R9
    busy_no_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && refresh_req) |=> $stable(refresh_row));
endmodule

// File: tb/mux_addr_dram_tb.sv
`timescale 1ns/1ps
module mux_addr_dram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_rd = 0, req_wdata = 0;
    logic [15:0] req_addr = '0;
    logic        busy, rd_ready;
    logic        row_stb = 0, col_stb = 0, close_row = 0, refresh_req = 0;
    logic        rd_nwr = 0, data_in = 0;
    logic [7:0]  addr_bus = '0;
    logic        data_out, row_open;
    logic [7:0]  refresh_row;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    mux_addr_dram u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of raw commands, then all pins idle again.
    task automatic pin(input logic rs, input logic cs, input logic cl, input logic rf,
                       input logic rd, input logic [7:0] a, input logic d);
        @(negedge clk);
        row_stb = rs; col_stb = cs; close_row = cl; refresh_req = rf;
        rd_nwr = rd; addr_bus = a; data_in = d;
        @(negedge clk);
        row_stb = 0; col_stb = 0; close_row = 0; refresh_req = 0;
    endtask

    task automatic t_reset();
        chk("R1 row_open", row_open, 0);
        chk("R1 data_out", data_out, 0);
        chk("R1 refresh_row", refresh_row, 0);
        chk("R1 busy", busy, 0);
        chk("R1 rd_ready", rd_ready, 0);
    endtask

    task automatic t_buffer();
        pin(1, 0, 0, 0, 0, 8'd5, 0);
        chk("R2 open", row_open, 1);
        pin(0, 1, 0, 0, 0, 8'd3, 1);
        pin(0, 1, 0, 0, 1, 8'd3, 0);
        chk("R3 read col3", data_out, 1);
        pin(0, 1, 0, 0, 0, 8'd3, 0);
        chk("R4 write keeps data_out", data_out, 1);
        pin(0, 1, 0, 0, 1, 8'd3, 0);
        chk("R4 read back col3", data_out, 0);
        pin(0, 1, 0, 0, 0, 8'd9, 1);
        pin(0, 1, 0, 0, 1, 8'd9, 0);
        chk("R3 read col9", data_out, 1);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
        chk("R5 closed", row_open, 0);
        pin(1, 0, 0, 0, 0, 8'd6, 0);
        pin(0, 1, 0, 0, 0, 8'd9, 0);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
        pin(1, 0, 0, 0, 0, 8'd5, 0);
        pin(0, 1, 0, 0, 1, 8'd9, 0);
        chk("R5 written back", data_out, 1);
        pin(1, 0, 0, 0, 0, 8'd6, 0);
        pin(0, 1, 0, 0, 1, 8'd9, 0);
        chk("R2 second open ignored", data_out, 1);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
    endtask

    task automatic t_no_row();
        pin(0, 1, 0, 0, 1, 8'd3, 0);
        chk("R6 read ignored", data_out, 1);
        pin(0, 1, 0, 0, 0, 8'd9, 0);
        pin(1, 0, 0, 0, 0, 8'd5, 0);
        pin(0, 1, 0, 0, 1, 8'd9, 0);
        chk("R6 write ignored", data_out, 1);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
    endtask

    task automatic t_refresh();
        for (int i = 0; i < 3; i++) pin(0, 0, 0, 1, 0, 8'd0, 0);
        chk("R7 count", refresh_row, 3);
        pin(1, 0, 0, 0, 0, 8'd5, 0);
        pin(0, 0, 0, 1, 0, 8'd0, 0);
        chk("R7 blocked while open", refresh_row, 3);
        pin(0, 0, 1, 1, 0, 8'd0, 0);
        chk("R10 close wins", row_open, 0);
        chk("R10 refresh dropped", refresh_row, 3);
        pin(0, 1, 0, 0, 1, 8'd3, 0);
        for (int i = 0; i < 253; i++) pin(0, 0, 0, 1, 0, 8'd0, 0);
        chk("R7 wrap", refresh_row, 0);
        pin(1, 0, 0, 0, 0, 8'd5, 0);
        pin(0, 1, 0, 0, 1, 8'd9, 0);
        chk("R7 data kept", data_out, 1);
        pin(1, 1, 0, 0, 1, 8'd3, 0);
        chk("R10 col dropped under row strobe", data_out, 1);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
    endtask

    // Flat request; checks busy/rd_ready in each phase, returns data_out.
    task automatic flat(input logic rd, input logic [15:0] a, input logic d,
                        output logic got);
        @(negedge clk);
        req_valid = 1; req_rd = rd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk("R8 busy p1", busy, 1);
        chk("R8 ready p1", rd_ready, 0);
        @(negedge clk);
        chk("R8 busy p2", busy, 1);
        @(negedge clk);
        chk("R8 busy p3", busy, 1);
        chk("R8 ready p3", rd_ready, rd);
        got = data_out;
        @(negedge clk);
        chk("R8 idle", busy, 0);
    endtask

    task automatic t_seq();
        logic g;
        flat(0, 16'h2140, 1, g);
        flat(0, 16'h2141, 0, g);
        flat(1, 16'h2140, 0, g);
        chk("R8 read 2140", g, 1);
        flat(1, 16'h2141, 0, g);
        chk("R8 read 2141", g, 0);
        pin(1, 0, 0, 0, 0, 8'h21, 0);
        pin(0, 1, 0, 0, 1, 8'h40, 0);
        chk("R8 row/col split", data_out, 1);
        @(negedge clk);
        req_valid = 1; req_rd = 1; req_addr = 16'h2140;
        @(negedge clk);
        req_valid = 0;
        chk("R8 not taken with row open", busy, 0);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
    endtask

    task automatic t_busy();
        logic [7:0] r0;
        r0 = refresh_row;
        @(negedge clk);
        req_valid = 1; req_rd = 1; req_addr = 16'h2140;
        @(negedge clk);
        req_addr = 16'h0505; refresh_req = 1; close_row = 1;
        col_stb = 1; rd_nwr = 0; addr_bus = 8'h40; data_in = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 ready", rd_ready, 1);
        chk("R9 read unaffected", data_out, 1);
        req_valid = 0; refresh_req = 0; close_row = 0; col_stb = 0;
        @(negedge clk);
        chk("R9 no restart", busy, 0);
        chk("R9 refresh ignored", refresh_row, r0);
        pin(1, 0, 0, 0, 0, 8'h21, 0);
        pin(0, 1, 0, 0, 1, 8'h40, 0);
        chk("R9 raw write ignored", data_out, 1);
        pin(0, 0, 1, 0, 0, 8'd0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_buffer();
        t_no_row();
        t_refresh();
        t_seq();
        t_busy();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule